// File: doc/BRIEF.md
# Dual-Bank Read Mode Controller

This block tracks the read mode of a flash array split into two banks, where one bank can be read while the other programs or erases. It decodes command writes (address, data byte, write strobe) into per-bank operation states. For every read address it decides whether the data comes from the array or from the bank's status register. A behavioural array model outside the block reports when a running operation finishes.

Each bank holds its own read mode. Starting a program or erase in a bank puts that bank into status mode and forces the other bank back to array mode. A read therefore returns status only when its address falls in the busy bank. The block also supports three steps on an erasing bank: suspending the erase, programming a different block of that bank while the erase is suspended, and resuming the erase afterwards. The array storage itself, cell timing and identification data are outside the block.

Top module: `dual_bank_rdmode`

## Requirements
- R1: After reset both banks are in array mode (bank_mode = 2'b00), both are ready, neither is suspended, and err_flag is 0.
- R2: A program (byte 40h, then any byte written to the target address) or an erase (byte 20h, then D0h at an address in the target bank) that is accepted sets bank_mode of that bank to 1 and clears its bank_ready, both visible after the edge that takes the second write.
- R3: When an operation is accepted in one bank, bank_mode of the other bank becomes 0 at the same edge.
- R4: Address bit AW-1 selects the bank (1 = bank b, index 1). rd_status equals bank_mode of the bank that rd_addr selects. status_out for that bank is {ready, erase-suspended, 0, err_flag, 4'b0000}, so bit 7 is ready, bit 6 is suspended and bit 4 is the reject flag.
- R5: Byte 70h written to a bank sets that bank's mode to status. Byte FFh sets it to array. The other bank's mode is not changed.
- R6: arr_done for a bank that is programming or erasing makes it ready. arr_done for a program run inside a suspended erase returns the bank to erase-suspended. arr_done is ignored in any other state.
- R7: Byte B0h written to a bank that is erasing suspends the erase. The bank then reports ready = 1 and suspended = 1.
- R8: While an erase is suspended, a program to a different block (address bits AW-2 down to BLK_BITS) of the same bank is accepted. The bank is then not ready and still suspended. A program to the suspended block is rejected.
- R9: Byte D0h written to a bank that is erase-suspended (not inside a program) resumes the erase: not ready, not suspended. D0h written while that program is still running is ignored.
- R10: A program or erase is rejected if the other bank is not idle, or if the target bank cannot accept it. A rejected operation sets err_flag and changes no bank state or mode.
- R11: err_flag stays set until reset.
- R12: An erase setup (20h) followed by any byte other than D0h is cancelled. That second byte has no other effect, even when it is a mode command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one write per cycle |
| cmd_addr | input | AW | Command write address |
| cmd_data | input | 8 | Command or data byte |
| arr_done | input | 2 | Per-bank completion pulse from the array model |
| rd_addr | input | AW | Read address |
| rd_status | output | 1 | 1: read returns status, 0: read returns array data |
| status_out | output | 8 | Status byte of the bank selected by rd_addr |
| bank_mode | output | 2 | Per-bank read mode, 1 = status |
| bank_ready | output | 2 | Per-bank ready (no operation running) |
| bank_susp | output | 2 | Per-bank erase-suspended |
| err_flag | output | 1 | Sticky rejected-operation flag |

## Verification
A wrong bank state shows up at bank_ready, bank_susp and status_out on the cycle after the edge that caused it. A wrong mode bit shows up at rd_status as soon as rd_addr points into that bank. Because the bench model is compared on every clock, an internal slip is reported within one cycle, even when it happens between two directed checks. A missed rejection shows up as err_flag staying low, and it stays visible at status bit 4 for the rest of the run.

// File: rtl/dual_bank_rdmode.sv
module dual_bank_rdmode #(
  parameter int AW       = 21,
  parameter int BLK_BITS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [7:0]    cmd_data,
  input  logic [1:0]    arr_done,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_status,
  output logic [7:0]    status_out,
  output logic [1:0]    bank_mode,
  output logic [1:0]    bank_ready,
  output logic [1:0]    bank_susp,
  output logic          err_flag
);
  localparam int BW = AW - 1 - BLK_BITS;
  localparam logic [7:0] C_ERASE = 8'h20;
  localparam logic [7:0] C_PROG  = 8'h40;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_GO    = 8'hD0;
  localparam logic [7:0] C_STAT  = 8'h70;
  localparam logic [7:0] C_ARR   = 8'hFF;

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERASE, S_ESUSP, S_PSUSP} bst_t;

  bst_t          st_q [2];
  bst_t          st_n [2];
  logic [1:0]    mode_q, mode_n;
  logic          pp_q, pp_n, pe_q, pe_n;
  logic [BW-1:0] blk_q, blk_n;
  logic          err_q, err_n;
  logic          start_fire;

  logic          wb;
  logic          ob;
  logic [BW-1:0] wblk;
  logic          rb;
  logic          unused_bits;

  assign wb   = cmd_addr[AW-1];
  assign ob   = ~wb;
  assign wblk = cmd_addr[AW-2:BLK_BITS];
  assign rb   = rd_addr[AW-1];
  assign unused_bits = ^{rd_addr[AW-2:0], cmd_addr[BLK_BITS-1:0]};

  always_comb begin
    st_n       = st_q;
    mode_n     = mode_q;
    pp_n       = pp_q;
    pe_n       = pe_q;
    blk_n      = blk_q;
    err_n      = err_q;
    start_fire = 1'b0;
    if (cmd_we) begin
      if (pp_q) begin
        pp_n = 1'b0;
        if (st_q[ob] == S_IDLE &&
            (st_q[wb] == S_IDLE || (st_q[wb] == S_ESUSP && wblk != blk_q))) begin
          if (st_q[wb] == S_IDLE) st_n[wb] = S_PROG;
          else                    st_n[wb] = S_PSUSP;
          mode_n[wb] = 1'b1;
          mode_n[ob] = 1'b0;
          start_fire = 1'b1;
        end else begin
          err_n = 1'b1;
        end
      end else if (pe_q) begin
        pe_n = 1'b0;
        if (cmd_data == C_GO) begin
          if (st_q[0] == S_IDLE && st_q[1] == S_IDLE) begin
            st_n[wb]   = S_ERASE;
            blk_n      = wblk;
            mode_n[wb] = 1'b1;
            mode_n[ob] = 1'b0;
            start_fire = 1'b1;
          end else begin
            err_n = 1'b1;
          end
        end
      end else begin
        case (cmd_data)
          C_PROG:  pp_n = 1'b1;
          C_ERASE: pe_n = 1'b1;
          C_STAT:  mode_n[wb] = 1'b1;
          C_ARR:   mode_n[wb] = 1'b0;
          C_SUSP:  if (st_q[wb] == S_ERASE) st_n[wb] = S_ESUSP;
          C_GO:    if (st_q[wb] == S_ESUSP) st_n[wb] = S_ERASE;
          default: ;
        endcase
      end
    end
    for (int b = 0; b < 2; b++) begin
      if (arr_done[b]) begin
        case (st_q[b])
          S_PROG, S_ERASE: st_n[b] = S_IDLE;
          S_PSUSP:         st_n[b] = S_ESUSP;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q[0] <= S_IDLE;
      st_q[1] <= S_IDLE;
      mode_q  <= 2'b00;
      pp_q    <= 1'b0;
      pe_q    <= 1'b0;
      blk_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q[0] <= st_n[0];
      st_q[1] <= st_n[1];
      mode_q  <= mode_n;
      pp_q    <= pp_n;
      pe_q    <= pe_n;
      blk_q   <= blk_n;
      err_q   <= err_n;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    assign bank_ready[g] = !(st_q[g] == S_PROG || st_q[g] == S_ERASE || st_q[g] == S_PSUSP);
    assign bank_susp[g]  = (st_q[g] == S_ESUSP || st_q[g] == S_PSUSP);
  end

  assign bank_mode  = mode_q;
  assign err_flag   = err_q;
  assign rd_status  = mode_q[rb];
  assign status_out = {bank_ready[rb], bank_susp[rb], 1'b0, err_q, 4'b0000};

  AST_ONE_BANK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q[0] != S_IDLE && st_q[1] != S_IDLE)); // R10
  AST_START_SETS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> bank_mode == ($past(wb) ? 2'b10 : 2'b01)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R11
  AST_DONE_READY0: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_done[0] && (st_q[0] == S_PROG || st_q[0] == S_ERASE)) |=> bank_ready[0]); // R6
  AST_DONE_READY1: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_done[1] && (st_q[1] == S_PROG || st_q[1] == S_ERASE)) |=> bank_ready[1]); // R6
  AST_SAME_BLOCK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && pp_q && st_q[wb] == S_ESUSP && wblk == blk_q) |=> err_flag); // R8
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !pp_q && !pe_q && cmd_data == C_GO && st_q[wb] == S_ESUSP)
      |=> (bank_susp == 2'b00 && bank_ready != 2'b11)); // R9
endmodule

// File: tb/tb_dual_bank_rdmode.sv
`timescale 1ns/1ps
module tb_dual_bank_rdmode;
  localparam int AW = 21;
  localparam int BLK_BITS = 15;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cmd_we = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic [1:0]    arr_done = '0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_status;
  logic [7:0]    status_out;
  logic [1:0]    bank_mode, bank_ready, bank_susp;
  logic          err_flag;

  dual_bank_rdmode #(.AW(AW), .BLK_BITS(BLK_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .arr_done(arr_done), .rd_addr(rd_addr),
    .rd_status(rd_status), .status_out(status_out), .bank_mode(bank_mode),
    .bank_ready(bank_ready), .bank_susp(bank_susp), .err_flag(err_flag));

  always #2 clk = ~clk;

  localparam logic [AW-1:0] A0 = 21'h000000;
  localparam logic [AW-1:0] A1 = 21'h008000;
  localparam logic [AW-1:0] B0 = 21'h100000;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program in suspend
  int m_st[2];
  int m_md[2];
  int m_pend;
  int m_blk;
  int m_err;

  function automatic int rdy(int s); return (s == 1 || s == 2 || s == 4) ? 0 : 1; endfunction
  function automatic int sus(int s); return (s == 3 || s == 4) ? 1 : 0; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st[0] = 0; m_st[1] = 0; m_md[0] = 0; m_md[1] = 0;
      m_pend = 0; m_blk = 0; m_err = 0;
    end else begin
      int old0, old1, b, o, blk;
      old0 = m_st[0]; old1 = m_st[1];
      b = int'(cmd_addr[AW-1]); o = 1 - b;
      blk = int'(cmd_addr[AW-2:BLK_BITS]);
      if (cmd_we) begin
        if (m_pend == 1) begin
          m_pend = 0;
          if (m_st[o] == 0 && (m_st[b] == 0 || (m_st[b] == 3 && blk != m_blk))) begin
            m_st[b] = (m_st[b] == 0) ? 1 : 4;
            m_md[b] = 1; m_md[o] = 0;
          end else m_err = 1;
        end else if (m_pend == 2) begin
          m_pend = 0;
          if (cmd_data == 8'hD0) begin
            if (m_st[0] == 0 && m_st[1] == 0) begin
              m_st[b] = 2; m_blk = blk; m_md[b] = 1; m_md[o] = 0;
            end else m_err = 1;
          end
        end else begin
          case (cmd_data)
            8'h40: m_pend = 1;
            8'h20: m_pend = 2;
            8'h70: m_md[b] = 1;
            8'hFF: m_md[b] = 0;
            8'hB0: if (m_st[b] == 2) m_st[b] = 3;
            8'hD0: if (m_st[b] == 3) m_st[b] = 2;
            default: ;
          endcase
        end
      end
      if (arr_done[0]) begin
        if (old0 == 1 || old0 == 2) m_st[0] = 0;
        else if (old0 == 4) m_st[0] = 3;
      end
      if (arr_done[1]) begin
        if (old1 == 1 || old1 == 2) m_st[1] = 0;
        else if (old1 == 4) m_st[1] = 3;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int rbk;
      rbk = int'(rd_addr[AW-1]);
      chk("R3/R5 bank_mode", int'(bank_mode), m_md[1] * 2 + m_md[0]);
      chk("R4 rd_status", int'(rd_status), m_md[rbk]);
      chk("R2/R6/R7/R9 bank_ready", int'(bank_ready), rdy(m_st[1]) * 2 + rdy(m_st[0]));
      chk("R7/R8/R9 bank_susp", int'(bank_susp), sus(m_st[1]) * 2 + sus(m_st[0]));
      chk("R10/R11 err_flag", int'(err_flag), m_err);
      chk("R4 status_out", int'(status_out),
          rdy(m_st[rbk]) * 128 + sus(m_st[rbk]) * 64 + m_err * 16);
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(posedge clk); #1; cmd_we = 1; cmd_addr = a; cmd_data = d;
    @(posedge clk); #1; cmd_we = 0;
  endtask

  task automatic done(int b);
    @(posedge clk); #1; arr_done[b] = 1'b1;
    @(posedge clk); #1; arr_done = '0;
  endtask

  task automatic rd(logic [AW-1:0] a);
    rd_addr = a; #0.5;
  endtask

  task automatic do_reset;
    @(posedge clk); #1; rst_n = 0;
    @(posedge clk); #1; rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #0.5;
    chk("R1 mode", int'(bank_mode), 0);
    chk("R1 ready", int'(bank_ready), 3);
    chk("R1 susp", int'(bank_susp), 0);
    chk("R1 err", int'(err_flag), 0);

    wr(A0, 8'h70); rd(A0);
    chk("R5 status mode a", int'(rd_status), 1);
    wr(B0, 8'h70);
    wr(A0, 8'hFF); rd(A0);
    chk("R5 array mode a", int'(rd_status), 0);
    chk("R5 bank b untouched", int'(bank_mode), 2);

    wr(A0, 8'h40); wr(A0 + 5, 8'h34);
    chk("R2 program sets mode a", int'(bank_mode[0]), 1);
    chk("R3 other bank forced to array", int'(bank_mode[1]), 0);
    chk("R2 bank a busy", int'(bank_ready), 2);
    rd(B0); chk("R4 idle bank reads array", int'(rd_status), 0);
    rd(A0); chk("R4 busy bank reads status", int'(status_out), 8'h00);

    wr(B0, 8'h20); wr(B0, 8'hD0);
    chk("R10 erase b rejected err", int'(err_flag), 1);
    chk("R10 bank b unchanged", int'(bank_ready), 2);
    chk("R10 modes unchanged", int'(bank_mode), 1);

    done(0);
    rd(A0); chk("R6 done makes ready", int'(status_out), 8'h90);
    wr(A0, 8'hFF); wr(B0, 8'h70);
    chk("R11 err still set", int'(err_flag), 1);

    do_reset; #0.5;
    chk("R1 err cleared by reset", int'(err_flag), 0);

    wr(A0, 8'h70); wr(A0, 8'h20); wr(A0, 8'hFF);
    rd(A0);
    chk("R12 cancelled erase no mode change", int'(rd_status), 1);
    chk("R12 no operation", int'(bank_ready), 3);

    wr(A0, 8'h20); wr(A0, 8'hD0); rd(A0);
    chk("R2 erase busy", int'(status_out), 8'h00);
    wr(A0, 8'hB0);
    chk("R7 suspended status", int'(status_out), 8'hC0);
    done(0);
    chk("R6 done ignored while suspended", int'(status_out), 8'hC0);

    wr(A1, 8'h40); wr(A1 + 3, 8'h55);
    chk("R8 program other block", int'(status_out), 8'h40);
    wr(A0, 8'hD0);
    chk("R9 resume ignored during program", int'(status_out), 8'h40);
    done(0);
    chk("R6 back to suspended", int'(status_out), 8'hC0);

    wr(A0, 8'h40); wr(A0 + 1, 8'h11);
    chk("R8 same block rejected", int'(status_out), 8'hD0);

    wr(A0, 8'hD0);
    chk("R9 resume", int'(status_out), 8'h10);
    done(0);
    chk("R6 erase finished", int'(status_out), 8'h90);

    do_reset;
    wr(B0, 8'h20); wr(B0, 8'hD0);
    rd(A0); chk("R4 read bank a while b erases", int'(rd_status), 0);
    rd(B0); chk("R4 read bank b status", int'(status_out), 8'h00);
    wr(A0, 8'h40); wr(A0, 8'h00);
    chk("R10 program a while b busy", int'(err_flag), 1);
    done(1);
    chk("R6 bank b ready", int'(bank_ready), 3);

    repeat (2) @(posedge clk);
    #1 finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule